// File: doc/BRIEF.md
# Eight-Lane SECDED Write Encoder

This block sits on the write path of a memory port, between the data source and the storage array. Each incoming write word holds eight 32-bit lanes. Every lane is protected on its own: it becomes a 39-bit codeword that can correct any single flipped bit and detect any two flipped bits. The eight codewords are packed side by side into a 312-bit output word.

Because partial writes are not supported, the per-byte write mask that goes with the output word is driven all-ones at all times. The valid/ready handshake goes straight from sink to source. A parameter can add one output register stage. That stage is a standard one-entry pipeline slot that holds its word while the downstream side stalls.

Top module: `secded_wr_encoder`

## Requirements
- R1: Lane i takes input bits [32i+31:32i] and drives output bits [39i+38:39i]. Inside a codeword, the data bits go into the positions 1..38 that are not powers of two. They fill those positions in ascending order, so data bit 0 lands in position 3 and data bit 31 lands in position 38.
- R2: The check bits sit at codeword positions 1, 2, 4, 8, 16 and 32. The bit at position 2^k is the XOR of all data positions whose index has bit k set. As a result, the XOR of the indices of all set bits in positions 1..38 is zero.
- R3: Codeword bit 0 is the XOR of bits 1..38, so every 39-bit codeword has even parity.
- R4: Every bit of the 39-bit output write mask is 1 at all times, including during reset.
- R5: With the output register disabled, out_valid equals in_valid and in_ready equals out_ready in the same cycle, and out_data is a function of in_data alone.
- R6: An all-zero data lane encodes to an all-zero codeword.
- R7: Changing one input lane changes no output bit outside that lane's 39-bit field.
- R8: With the output register enabled, a word accepted on a clock edge appears on the output after that edge. While out_valid is 1 and out_ready is 0, the output word and out_valid hold and in_ready is 0. in_ready is 1 whenever the slot is empty or out_ready is 1.
- R9: With the output register enabled, out_valid is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only by the registered variant) |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sink word valid |
| in_ready | output | 1 | Sink may transfer |
| in_data | input | 256 | Eight 32-bit data lanes |
| out_valid | output | 1 | Source word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 312 | Eight packed 39-bit codewords |
| out_wmask | output | 39 | Per-byte write mask, always all-ones |

## Verification
The bench drives single-bit lanes, which expose a data bit placed one slot off or a check bit that covers the wrong group: either fault shows up as a wrong syndrome or a wrong data position. All-zero and all-one lanes catch a parity bit that is inverted or computed over the wrong span. Flipping one lane while keeping the rest fixed exposes lane fields that are offset or overlap and leak into a neighbour. The registered variant is stalled with out_ready low to catch a slot that overwrites its word or drops valid under backpressure.

// File: rtl/secded_wr_encoder.sv
module secded_wr_encoder #(
  parameter int LANES   = 8,
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [LANES*DATA_W-1:0]       in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [LANES*(DATA_W+7)-1:0]   out_data,
  output logic [(LANES*(DATA_W+7)+7)/8-1:0] out_wmask
);

  localparam int CHK_W  = 6;
  localparam int CODE_W = DATA_W + CHK_W + 1;
  localparam int OUT_W  = LANES * CODE_W;
  localparam int MASK_W = (OUT_W + 7) / 8;

  function automatic logic [CODE_W-1:0] enc_lane(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < CHK_W; k++)
      for (int p = 1; p < CODE_W; p++)
        if (((p & (p - 1)) != 0) && p[k])
          c[1 << k] = c[1 << k] ^ c[p];
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(input logic [CODE_W-1:0] c);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p < CODE_W; p++)
      if (c[p]) s = s ^ CHK_W'(p);
    return s;
  endfunction

  logic [OUT_W-1:0] enc_word;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign enc_word[i*CODE_W +: CODE_W] = enc_lane(in_data[i*DATA_W +: DATA_W]);

    AST_LANE_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (^out_data[i*CODE_W +: CODE_W]) == 1'b0); // R3
    AST_LANE_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> syndrome(out_data[i*CODE_W +: CODE_W]) == '0); // R2
  end

  assign out_wmask = '1;

  if (REG_OUT) begin : g_reg
    logic             vld_q;
    logic [OUT_W-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else if (in_valid && in_ready) begin
        vld_q <= 1'b1;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (in_valid && in_ready) dat_q <= enc_word;
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R8
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = enc_word;

    AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data[DATA_W-1:0] == '0) |-> (out_data[CODE_W-1:0] == '0)); // R6
  end

  AST_MASK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    &out_wmask); // R4

endmodule

// File: tb/tb_secded_wr_encoder.sv
`timescale 1ns/1ps
module tb_secded_wr_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         c_in_valid, c_in_ready, c_out_valid, c_out_ready;
  logic [255:0] c_in_data;
  logic [311:0] c_out_data;
  logic [38:0]  c_wmask;

  logic         r_in_valid, r_in_ready, r_out_valid, r_out_ready;
  logic [255:0] r_in_data;
  logic [311:0] r_out_data;
  logic [38:0]  r_wmask;

  int n_run = 0;
  int n_fail = 0;

  secded_wr_encoder #(.REG_OUT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .in_data(c_in_data), .out_valid(c_out_valid), .out_ready(c_out_ready),
    .out_data(c_out_data), .out_wmask(c_wmask));

  secded_wr_encoder #(.REG_OUT(1'b1)) dut_reg (
    .clk(clk), .rst_n(rst_n), .in_valid(r_in_valid), .in_ready(r_in_ready),
    .in_data(r_in_data), .out_valid(r_out_valid), .out_ready(r_out_ready),
    .out_data(r_out_data), .out_wmask(r_wmask));

  // Reference: place data, then pick check bits so the index syndrome is zero.
  function automatic logic [38:0] ref_lane(input logic [31:0] d);
    logic [38:0] c;
    logic [5:0]  s;
    int j;
    c = '0; s = '0; j = 0;
    for (int p = 3; p < 39; p++) begin
      if (p != 4 && p != 8 && p != 16 && p != 32) begin
        c[p] = d[j];
        if (d[j]) s = s ^ 6'(p);
        j++;
      end
    end
    for (int k = 0; k < 6; k++) c[1 << k] = s[k];
    c[0] = ^c[38:1];
    return c;
  endfunction

  function automatic logic [311:0] ref_word(input logic [255:0] d);
    logic [311:0] w;
    for (int i = 0; i < 8; i++) w[39*i +: 39] = ref_lane(d[32*i +: 32]);
    return w;
  endfunction

  function automatic logic [255:0] rnd_word();
    logic [255:0] w;
    for (int i = 0; i < 8; i++) w[32*i +: 32] = $urandom;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [311:0] act, input logic [311:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] a, b;
    logic [311:0] ea, eb;
    void'($urandom(32'd1234));
    c_in_valid = 0; c_out_ready = 0; c_in_data = '0;
    r_in_valid = 0; r_out_ready = 0; r_in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(c_wmask == '1, "R4 mask in reset", 312'(c_wmask), 312'({39{1'b1}}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(r_out_valid == 1'b0, "R9 reg valid after reset", 312'(r_out_valid), 312'(0));
    chk(r_wmask == '1, "R4 mask reg", 312'(r_wmask), 312'({39{1'b1}}));

    // R6 zero word
    c_in_data = '0; #1;
    chk(c_out_data == '0, "R6 zero lanes", c_out_data, '0);

    // R1 known positions: data bit 0 -> position 3, bit 31 -> position 38
    c_in_data = '0; c_in_data[0] = 1'b1; #1;
    chk(c_out_data[38:0] == 39'h000000000F, "R1 data bit0 at pos3", 312'(c_out_data[38:0]), 312'(39'h0F));
    c_in_data = '0; c_in_data[32*7+31] = 1'b1; #1;
    chk(c_out_data[39*7+38] == 1'b1 && c_out_data[39*7-1:0] == '0,
        "R1 lane7 bit31 at pos38", c_out_data, ref_word(c_in_data));

    // Single-bit lanes, every bit of lane 0 and lane 5
    for (int b2 = 0; b2 < 32; b2++) begin
      c_in_data = '0; c_in_data[b2] = 1'b1; c_in_data[160 + b2] = 1'b1; #1;
      chk(c_out_data == ref_word(c_in_data), "R2 single-bit lanes", c_out_data, ref_word(c_in_data));
    end

    // All ones
    c_in_data = '1; #1;
    chk(c_out_data == ref_word(c_in_data), "R3 all-ones lanes", c_out_data, ref_word(c_in_data));
    for (int i = 0; i < 8; i++)
      chk((^c_out_data[39*i +: 39]) == 1'b0, "R3 even parity", 312'(c_out_data[39*i +: 39]), '0);

    // Random words, handshake pass-through
    for (int t = 0; t < 60; t++) begin
      c_in_data = rnd_word();
      c_in_valid = 1'($urandom); c_out_ready = 1'($urandom);
      if (t % 7 == 0) c_in_data[32*(t % 8) +: 32] = '0;
      #1;
      chk(c_out_data == ref_word(c_in_data), "R1 R2 random", c_out_data, ref_word(c_in_data));
      chk(c_out_valid == c_in_valid && c_in_ready == c_out_ready, "R5 handshake",
          312'({c_out_valid, c_in_ready}), 312'({c_in_valid, c_out_ready}));
      if (t % 7 == 0)
        chk(c_out_data[39*(t % 8) +: 39] == '0, "R6 zero lane", 312'(c_out_data[39*(t % 8) +: 39]), '0);
      chk(c_wmask == '1, "R4 mask", 312'(c_wmask), 312'({39{1'b1}}));
    end

    // Lane isolation
    for (int l = 0; l < 8; l++) begin
      a = rnd_word(); c_in_data = a; #1; ea = c_out_data;
      b = a; b[32*l +: 32] = ~a[32*l +: 32]; c_in_data = b; #1; eb = c_out_data;
      for (int i = 0; i < 8; i++)
        if (i != l)
          chk(ea[39*i +: 39] == eb[39*i +: 39], "R7 other lane stable",
              312'(eb[39*i +: 39]), 312'(ea[39*i +: 39]));
    end

    // Registered variant
    a = rnd_word(); b = rnd_word();
    @(negedge clk);
    r_in_valid = 1; r_in_data = a; r_out_ready = 1;
    @(negedge clk);
    chk(r_out_valid && r_out_data == ref_word(a), "R8 one cycle latency", r_out_data, ref_word(a));
    r_in_data = b; r_out_ready = 0; #1;
    chk(r_in_ready == 1'b0, "R8 ready low when stalled", 312'(r_in_ready), '0);
    @(negedge clk);
    chk(r_out_valid && r_out_data == ref_word(a), "R8 hold under stall", r_out_data, ref_word(a));
    r_out_ready = 1; #1;
    chk(r_in_ready == 1'b1, "R8 ready when drained", 312'(r_in_ready), 312'(1));
    @(negedge clk);
    chk(r_out_valid && r_out_data == ref_word(b), "R8 next word", r_out_data, ref_word(b));
    r_in_valid = 0;
    @(negedge clk);
    chk(r_out_valid == 1'b0, "R8 empties", 312'(r_out_valid), '0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule